// File: doc/BRIEF.md
# Triplicated configuration register file

This block keeps the global configuration of a chip in a small array of words. Every stored bit is held in three independent copies, and a bitwise majority vote produces the value that the rest of the chip uses. The voted contents of the whole array are driven continuously onto a wide parallel bus, so configuration consumers never have to issue reads. A command port carries writes from the command decoder and also reads, which return one voted word or the error counter over a response stream.

The voter does not repair the copies. A disagreement in any bit of a word raises that word's error flag, and the flag stays up until the word is written again. The flags of all words are combined into one summary flag. Each rising edge of that summary flag increments a saturating error counter. The counter can be cleared with a dedicated pulse or by a read-and-clear command. Two active-low reset inputs wipe the array, but only when both are low at the same clock edge, so a glitch on one reset line cannot erase the configuration.

A fault hook lets a testbench invert one chosen copy of one chosen bit, which exercises the voting and flagging paths. The command port uses valid/ready: a command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a read result is waiting and `rd_ready` is low, so writes also stall behind an unconsumed result. `rd_valid` and `rd_data` stay unchanged until they are consumed by `rd_ready`.

Top module: `cfg_tmr_regfile`

## Requirements
- R1: On a rising edge where `rst_a_n` and `rst_b_n` are both low, every copy of every bit becomes 0, `err_count` becomes 0 and `rd_valid` becomes 0.
- R2: While only one of the two reset inputs is low, the stored contents and `cfg_out` do not change because of the reset.
- R3: An accepted command with `cmd_we`=1 loads `cmd_wdata` into all three copies of word `cmd_addr`, and `cfg_out[cmd_addr*WIDTH +: WIDTH]` shows it after that edge.
- R4: An accepted command with `cmd_we`=0 and `cmd_cnt_sel`=0 raises `rd_valid` after that edge, with `rd_data` equal to the voted word at `cmd_addr`.
- R5: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold and `cmd_ready` is low. Otherwise `cmd_ready` is high.
- R6: Each bit of `cfg_out` is the majority of its three copies, so a single inverted copy is masked and two inverted copies change the output.
- R7: `word_err[w]` is high while any bit of word w differs among its copies, and `any_err` is the OR of all word flags.
- R8: Disagreements are not corrected. A word flag stays high until the next write to that word, and that write clears it.
- R9: `err_count` increases by one on the edge after the edge where `any_err` rose from 0 to 1, stays unchanged while `any_err` remains high, and saturates at 2^CNT_W-1.
- R10: A pulse on `err_clr`, or an accepted command with `cmd_we`=0 and `cmd_cnt_sel`=1, sets `err_count` to 0. The read-and-clear command returns the pre-clear count, zero-extended, on `rd_data`. A clear takes priority over an increment in the same cycle.
- R11: With `flip_en` high, the copy selected by `flip_copy` (0, 1 or 2) of bit `flip_bit` in word `flip_word` is inverted at the edge. `flip_copy`=3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_a_n | input | 1 | First active-low wipe request |
| rst_b_n | input | 1 | Second active-low wipe request |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_we | input | 1 | 1 = write word, 0 = read |
| cmd_cnt_sel | input | 1 | On a read, return and clear the error counter |
| cmd_addr | input | $clog2(WORDS) | Word address shared by write and read |
| cmd_wdata | input | WIDTH | Write data |
| rd_valid | output | 1 | Read result present |
| rd_ready | input | 1 | Read result consumed |
| rd_data | output | WIDTH | Read result |
| cfg_out | output | WORDS*WIDTH | Voted contents, word w at bits w*WIDTH |
| word_err | output | WORDS | Per-word copy disagreement flags |
| any_err | output | 1 | OR of all word flags |
| err_count | output | CNT_W | Saturating count of rising edges of any_err |
| err_clr | input | 1 | Clear the error counter |
| flip_en | input | 1 | Fault hook enable |
| flip_copy | input | 2 | Copy to invert (3 = none) |
| flip_word | input | $clog2(WORDS) | Word of the bit to invert |
| flip_bit | input | $clog2(WIDTH) | Bit position to invert |

## Verification
The properties assume that both reset inputs are low together at the first clock edge and that every input carries a defined value from time zero. They also assume that the fault hook stays idle in any cycle where a write-cleanliness or flag-persistence claim is made, which is why those properties exclude cycles with `flip_en` high. The stimulus starts with a dual reset, changes inputs only one nanosecond after a rising edge, and never issues a fault injection in the same cycle as a write. The counter-step and saturation properties are checked against a small counter width, so saturation is reached within the run.

// File: rtl/cfg_tmr_pkg.sv
package cfg_tmr_pkg;

  localparam int unsigned NUM_COPIES = 3;

  typedef enum logic [1:0] {
    COPY_A    = 2'd0,
    COPY_B    = 2'd1,
    COPY_C    = 2'd2,
    COPY_NONE = 2'd3
  } copy_sel_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/cfg_tmr_copy_bank.sv
// One of the three storage copies, with its own private write decoder.
module cfg_tmr_copy_bank #(
  parameter int unsigned WORDS   = 32,
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned COPY_ID = 0,
  localparam int unsigned AW = $clog2(WORDS),
  localparam int unsigned BW = $clog2(WIDTH)
) (
  input  logic                   clk,
  input  logic                   wipe,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [WIDTH-1:0]       wr_data,
  input  logic                   flip_en,
  input  logic [1:0]             flip_copy,
  input  logic [AW-1:0]          flip_word,
  input  logic [BW-1:0]          flip_bit,
  output logic [WORDS*WIDTH-1:0] bits
);

  logic             mine_flip;
  logic [WIDTH-1:0] flip_mask;

  assign mine_flip = flip_en && (flip_copy == 2'(COPY_ID));
  assign flip_mask = WIDTH'(1) << flip_bit;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic             load_hit;
    logic             flip_hit;
    logic [WIDTH-1:0] cell_q;
    logic [WIDTH-1:0] cell_d;

    // Private decode per copy: a glitch here reaches only this copy.
    assign load_hit = wr_en && (wr_addr == AW'(w));
    assign flip_hit = mine_flip && (flip_word == AW'(w));
    assign cell_d   = (load_hit ? wr_data : cell_q) ^ (flip_hit ? flip_mask : '0);

    always_ff @(posedge clk) begin
      if (wipe) begin
        cell_q <= '0;
      end else begin
        cell_q <= cell_d;
      end
    end

    assign bits[w*WIDTH +: WIDTH] = cell_q;
  end

endmodule

// File: rtl/cfg_tmr_voter.sv
// Bitwise majority and per-word disagreement detection, no write-back.
module cfg_tmr_voter #(
  parameter int unsigned WORDS = 32,
  parameter int unsigned WIDTH = 16
) (
  input  logic [WORDS*WIDTH-1:0] copy_a,
  input  logic [WORDS*WIDTH-1:0] copy_b,
  input  logic [WORDS*WIDTH-1:0] copy_c,
  output logic [WORDS*WIDTH-1:0] voted,
  output logic [WORDS-1:0]       word_err
);

  import cfg_tmr_pkg::*;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WIDTH-1:0] a_w;
    logic [WIDTH-1:0] b_w;
    logic [WIDTH-1:0] c_w;
    logic [WIDTH-1:0] disagree;

    assign a_w      = copy_a[w*WIDTH +: WIDTH];
    assign b_w      = copy_b[w*WIDTH +: WIDTH];
    assign c_w      = copy_c[w*WIDTH +: WIDTH];
    assign disagree = (a_w ^ b_w) | (a_w ^ c_w);
    assign word_err[w] = |disagree;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign voted[w*WIDTH + b] = maj3(a_w[b], b_w[b], c_w[b]);
    end
  end

endmodule

// File: rtl/cfg_tmr_err_counter.sv
// Counts rising edges of the summary flag, saturating; clear beats increment.
module cfg_tmr_err_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             wipe,
  input  logic             flag_in,
  input  logic             clear_req,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic flag_q;
  logic rise;

  assign rise = flag_in && !flag_q;

  always_ff @(posedge clk) begin
    if (wipe) begin
      flag_q <= 1'b0;
      count  <= '0;
    end else begin
      flag_q <= flag_in;
      if (clear_req) begin
        count <= '0;
      end else if (rise && (count != CNT_MAX)) begin
        count <= count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_tmr_regfile.sv
module cfg_tmr_regfile #(
  parameter int unsigned WORDS = 32,
  parameter int unsigned WIDTH = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned AW = $clog2(WORDS),
  localparam int unsigned BW = $clog2(WIDTH)
) (
  input  logic                   clk,
  input  logic                   rst_a_n,
  input  logic                   rst_b_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic                   cmd_we,
  input  logic                   cmd_cnt_sel,
  input  logic [AW-1:0]          cmd_addr,
  input  logic [WIDTH-1:0]       cmd_wdata,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [WIDTH-1:0]       rd_data,
  output logic [WORDS*WIDTH-1:0] cfg_out,
  output logic [WORDS-1:0]       word_err,
  output logic                   any_err,
  output logic [CNT_W-1:0]       err_count,
  input  logic                   err_clr,
  input  logic                   flip_en,
  input  logic [1:0]             flip_copy,
  input  logic [AW-1:0]          flip_word,
  input  logic [BW-1:0]          flip_bit
);

  import cfg_tmr_pkg::*;

  logic wipe;
  logic cmd_take;
  logic wr_fire;
  logic rd_fire;
  logic cnt_rd_fire;

  logic [WORDS*WIDTH-1:0] copy_bits [NUM_COPIES];

  // Both wipe requests must coincide.
  assign wipe        = !rst_a_n && !rst_b_n;
  assign cmd_ready   = !rd_valid || rd_ready;
  assign cmd_take    = cmd_valid && cmd_ready;
  assign wr_fire     = cmd_take && cmd_we;
  assign rd_fire     = cmd_take && !cmd_we;
  assign cnt_rd_fire = rd_fire && cmd_cnt_sel;

  for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
    cfg_tmr_copy_bank #(
      .WORDS  (WORDS),
      .WIDTH  (WIDTH),
      .COPY_ID(c)
    ) i_bank (
      .clk      (clk),
      .wipe     (wipe),
      .wr_en    (wr_fire),
      .wr_addr  (cmd_addr),
      .wr_data  (cmd_wdata),
      .flip_en  (flip_en),
      .flip_copy(flip_copy),
      .flip_word(flip_word),
      .flip_bit (flip_bit),
      .bits     (copy_bits[c])
    );
  end

  cfg_tmr_voter #(
    .WORDS(WORDS),
    .WIDTH(WIDTH)
  ) i_voter (
    .copy_a  (copy_bits[0]),
    .copy_b  (copy_bits[1]),
    .copy_c  (copy_bits[2]),
    .voted   (cfg_out),
    .word_err(word_err)
  );

  assign any_err = |word_err;

  cfg_tmr_err_counter #(
    .CNT_W(CNT_W)
  ) i_err_cnt (
    .clk      (clk),
    .wipe     (wipe),
    .flag_in  (any_err),
    .clear_req(err_clr || cnt_rd_fire),
    .count    (err_count)
  );

  // Read response stage: holds until consumed.
  always_ff @(posedge clk) begin
    if (wipe) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rd_fire) begin
      rd_valid <= 1'b1;
      rd_data  <= cmd_cnt_sel ? WIDTH'(err_count) : cfg_out[cmd_addr*WIDTH +: WIDTH];
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_tmr_regfile_chk.sv
module cfg_tmr_regfile_chk #(
  parameter int unsigned WORDS = 32,
  parameter int unsigned WIDTH = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input logic                   clk,
  input logic                   rst_a_n,
  input logic                   rst_b_n,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic                   cmd_we,
  input logic                   cmd_cnt_sel,
  input logic [AW-1:0]          cmd_addr,
  input logic                   rd_valid,
  input logic                   rd_ready,
  input logic [WIDTH-1:0]       rd_data,
  input logic [WORDS*WIDTH-1:0] cfg_out,
  input logic [WORDS-1:0]       word_err,
  input logic                   any_err,
  input logic [CNT_W-1:0]       err_count,
  input logic                   err_clr,
  input logic                   flip_en
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic both_low;
  logic wr_acc;
  logic cnt_clr;

  assign both_low = !rst_a_n && !rst_b_n;
  assign wr_acc   = cmd_valid && cmd_ready && cmd_we;
  assign cnt_clr  = err_clr || (cmd_valid && cmd_ready && !cmd_we && cmd_cnt_sel);

  AST_DUAL_RESET_WIPES: assert property (@(posedge clk)
    both_low |=> (cfg_out == '0) && (err_count == '0) && !rd_valid); // R1

  AST_SINGLE_RESET_INERT: assert property (@(posedge clk) disable iff (both_low)
    (rst_a_n != rst_b_n) && !wr_acc && !flip_en |=> $stable(cfg_out)); // R2

  AST_WRITE_CLEANS_WORD: assert property (@(posedge clk) disable iff (both_low)
    wr_acc && !flip_en |=> !word_err[$past(cmd_addr)]); // R8

  AST_FLAG_PERSISTS: assert property (@(posedge clk) disable iff (both_low)
    any_err && !wr_acc && !flip_en |=> any_err); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (both_low)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (both_low)
    (err_count == CNT_MAX) && !cnt_clr |=> (err_count == CNT_MAX)); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (both_low)
    !cnt_clr |=> (err_count == $past(err_count)) ||
                 (err_count == CNT_W'($past(err_count) + 1'b1))); // R9

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (both_low)
    cnt_clr |=> (err_count == '0)); // R10

endmodule

bind cfg_tmr_regfile cfg_tmr_regfile_chk #(
  .WORDS(WORDS),
  .WIDTH(WIDTH),
  .CNT_W(CNT_W)
) i_chk (
  .clk        (clk),
  .rst_a_n    (rst_a_n),
  .rst_b_n    (rst_b_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_we     (cmd_we),
  .cmd_cnt_sel(cmd_cnt_sel),
  .cmd_addr   (cmd_addr),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .cfg_out    (cfg_out),
  .word_err   (word_err),
  .any_err    (any_err),
  .err_count  (err_count),
  .err_clr    (err_clr),
  .flip_en    (flip_en)
);

// File: tb/test_cfg_tmr_regfile.sv
module test_cfg_tmr_regfile;

  localparam int unsigned WORDS = 32;
  localparam int unsigned WIDTH = 16;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned AW    = 5;
  localparam int unsigned BW    = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                   rst_a_n     = 1'b0;
  logic                   rst_b_n     = 1'b0;
  logic                   cmd_valid   = 1'b0;
  logic                   cmd_ready;
  logic                   cmd_we      = 1'b0;
  logic                   cmd_cnt_sel = 1'b0;
  logic [AW-1:0]          cmd_addr    = '0;
  logic [WIDTH-1:0]       cmd_wdata   = '0;
  logic                   rd_valid;
  logic                   rd_ready    = 1'b1;
  logic [WIDTH-1:0]       rd_data;
  logic [WORDS*WIDTH-1:0] cfg_out;
  logic [WORDS-1:0]       word_err;
  logic                   any_err;
  logic [CNT_W-1:0]       err_count;
  logic                   err_clr     = 1'b0;
  logic                   flip_en     = 1'b0;
  logic [1:0]             flip_copy   = '0;
  logic [AW-1:0]          flip_word   = '0;
  logic [BW-1:0]          flip_bit    = '0;

  cfg_tmr_regfile #(.WORDS(WORDS), .WIDTH(WIDTH), .CNT_W(CNT_W)) i_cfg_tmr_regfile (
    .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we),
    .cmd_cnt_sel(cmd_cnt_sel), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .cfg_out(cfg_out), .word_err(word_err), .any_err(any_err),
    .err_count(err_count), .err_clr(err_clr),
    .flip_en(flip_en), .flip_copy(flip_copy), .flip_word(flip_word), .flip_bit(flip_bit)
  );

  int               n_checks = 0;
  int               n_fail   = 0;
  bit               done     = 1'b0;
  int               exp_cnt  = 0;
  logic [WIDTH-1:0] exp_mem [WORDS];
  logic [WIDTH-1:0] exp_q [$];
  logic [WIDTH-1:0] mon_exp;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] word_of(input int w);
    return cfg_out[w*WIDTH +: WIDTH];
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(input int a, input logic [WIDTH-1:0] d);
    cmd_valid = 1'b1; cmd_we = 1'b1; cmd_cnt_sel = 1'b0;
    cmd_addr = AW'(a); cmd_wdata = d;
    do @(negedge clk); while (!cmd_ready);
    exp_mem[a] = d;
    tick();
    cmd_valid = 1'b0; cmd_we = 1'b0;
  endtask

  // Driver: pushes the expected result when the command is taken.
  task automatic do_read(input int a, input bit sel);
    cmd_valid = 1'b1; cmd_we = 1'b0; cmd_cnt_sel = sel; cmd_addr = AW'(a);
    do @(negedge clk); while (!cmd_ready);
    if (sel) begin
      exp_q.push_back(WIDTH'(exp_cnt));
      exp_cnt = 0;
    end else begin
      exp_q.push_back(exp_mem[a]);
    end
    tick();
    cmd_valid = 1'b0; cmd_cnt_sel = 1'b0;
  endtask

  task automatic do_flip(input int c, input int w, input int b);
    flip_en = 1'b1; flip_copy = 2'(c); flip_word = AW'(w); flip_bit = BW'(b);
    tick();
    flip_en = 1'b0;
  endtask

  // Monitor: pops and compares each consumed read result (R4, R10).
  always @(negedge clk) begin
    if ((rst_a_n || rst_b_n) && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R4 unexpected result actual=%0h expected=none", rd_data);
      end else begin
        mon_exp = exp_q.pop_front();
        chk("R4 read result", 32'(rd_data), 32'(mon_exp));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) exp_mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg_out after wipe", 32'(cfg_out == '0), 32'd1);
    chk("R1 err_count after wipe", 32'(err_count), 32'd0);
    chk("R1 rd_valid after wipe", 32'(rd_valid), 32'd0);
    chk("R7 any_err after wipe", 32'(any_err), 32'd0);
    tick();

    // R3 writes and static outputs
    do_write(0, 16'hA5A5);
    do_write(31, 16'hFFFF);
    do_write(7, 16'h1234);
    @(negedge clk);
    chk("R3 word0", 32'(word_of(0)), 32'hA5A5);
    chk("R3 word31", 32'(word_of(31)), 32'hFFFF);
    chk("R3 word7", 32'(word_of(7)), 32'h1234);
    tick();
    // R4 reads through the scoreboard
    do_read(0, 1'b0);
    do_read(31, 1'b0);
    do_read(7, 1'b0);
    tick(); tick();

    // R6 R7 R11 single flip is masked but flagged
    do_flip(1, 7, 3);
    @(negedge clk);
    chk("R6 single flip masked", 32'(word_of(7)), 32'h1234);
    chk("R7 word_err[7] set", 32'(word_err[7]), 32'd1);
    chk("R7 word_err[0] clear", 32'(word_err[0]), 32'd0);
    chk("R7 any_err set", 32'(any_err), 32'd1);
    tick();
    @(negedge clk);
    chk("R9 count after rise", 32'(err_count), 32'd1);
    exp_cnt = 1;
    tick(); tick(); tick();
    @(negedge clk);
    chk("R8 flag persists", 32'(word_err[7]), 32'd1);
    chk("R9 no recount while high", 32'(err_count), 32'd1);
    tick();

    // R6 second copy flipped changes voted bit
    do_flip(2, 7, 3);
    @(negedge clk);
    chk("R6 double flip visible", 32'(word_of(7)), 32'h123C);
    tick();
    @(negedge clk);
    chk("R9 count unchanged", 32'(err_count), 32'd1);
    tick();

    // R8 write repairs
    do_write(7, 16'h5555);
    @(negedge clk);
    chk("R8 write clears word_err", 32'(word_err[7]), 32'd0);
    chk("R8 write clears any_err", 32'(any_err), 32'd0);
    chk("R8 rewritten word", 32'(word_of(7)), 32'h5555);
    tick();

    // R10 read-and-clear
    do_flip(0, 0, 15);
    tick();
    @(negedge clk);
    chk("R9 second rise", 32'(err_count), 32'd2);
    exp_cnt = 2;
    tick();
    do_read(0, 1'b1);
    @(negedge clk);
    chk("R10 read-and-clear zeroes", 32'(err_count), 32'd0);
    tick(); tick();
    @(negedge clk);
    chk("R10 no recount while flag high", 32'(err_count), 32'd0);
    tick();

    // R11 copy select 3 does nothing
    do_flip(3, 31, 0);
    @(negedge clk);
    chk("R11 copy3 no flag", 32'(word_err[31]), 32'd0);
    chk("R11 copy3 data", 32'(word_of(31)), 32'hFFFF);
    tick();

    // R10 err_clr pulse
    do_write(0, 16'hA5A5);
    do_flip(0, 0, 0);
    tick();
    @(negedge clk);
    chk("R9 count before clr", 32'(err_count), 32'd1);
    tick();
    err_clr = 1'b1;
    tick();
    err_clr = 1'b0;
    @(negedge clk);
    chk("R10 err_clr zeroes", 32'(err_count), 32'd0);
    tick();
    do_write(0, 16'hA5A5);

    // R9 saturation: 20 rises on a 4-bit counter
    for (int k = 0; k < 20; k++) begin
      do_flip(0, 5, 0);
      do_flip(0, 5, 0);
    end
    tick();
    @(negedge clk);
    chk("R9 saturated", 32'(err_count), 32'd15);
    tick();
    exp_cnt = 15;
    do_read(0, 1'b1);
    tick(); tick();

    // R5 back-pressure
    rd_ready = 1'b0;
    do_read(31, 1'b0);
    @(negedge clk);
    chk("R5 rd_valid up", 32'(rd_valid), 32'd1);
    chk("R5 cmd_ready low", 32'(cmd_ready), 32'd0);
    tick(); tick();
    @(negedge clk);
    chk("R5 rd_valid held", 32'(rd_valid), 32'd1);
    chk("R5 rd_data held", 32'(rd_data), 32'hFFFF);
    tick();
    rd_ready = 1'b1;
    tick();
    @(negedge clk);
    chk("R5 released", 32'(rd_valid), 32'd0);
    tick();

    // R2 one reset alone is ignored
    do_write(3, 16'h0F0F);
    rst_a_n = 1'b0;
    tick(); tick(); tick();
    rst_a_n = 1'b1;
    @(negedge clk);
    chk("R2 rst_a_n alone word3", 32'(word_of(3)), 32'h0F0F);
    tick();
    rst_b_n = 1'b0;
    tick(); tick(); tick();
    rst_b_n = 1'b1;
    @(negedge clk);
    chk("R2 rst_b_n alone word31", 32'(word_of(31)), 32'hFFFF);
    chk("R2 rst_b_n alone word3", 32'(word_of(3)), 32'h0F0F);
    tick();

    // R1 both together wipe
    do_flip(0, 9, 2);
    rst_a_n = 1'b0; rst_b_n = 1'b0;
    tick(); tick();
    rst_a_n = 1'b1; rst_b_n = 1'b1;
    @(negedge clk);
    chk("R1 dual wipe cfg_out", 32'(cfg_out == '0), 32'd1);
    chk("R1 dual wipe err_count", 32'(err_count), 32'd0);
    chk("R1 dual wipe flags", 32'(word_err), 32'd0);
    tick(); tick();

    chk("R4 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule